// File: doc/BRIEF.md
# Digital Audio Receiver Side-Information Extractor

This block sits behind the biphase decoder of a two-channel digital audio receiver. A strobe delivers each decoded subframe: its audio payload, its validity, user, channel-status and parity bits, a code for its preamble type, a flag for a biphase coding violation, and the receiver's lock state. From these the block produces per-sample side outputs. It passes on the channel-status and user bits, raises an error flag, and drives a combined validity-or-error output that an interpolation stage can use to conceal bad samples.

The block also tracks the frame position inside the 192-frame channel-status block. It drives a block-window output that is high for the first 32 frames of each block and low for the other 160. Frames are counted on first-channel subframes. A block-start preamble always forces the count back to frame 0. While lock is absent the error outputs are forced high and the frame position is discarded. The block-window output stays low until the next block-start preamble.

Top module: `aud_rx_side_info`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: On a strobe, `cs_out` and `usr_out` take the subframe's channel-status and user bits. They keep those values until the next strobe.
- R3: Parity is even over the audio payload and the V, U, C and P bits. A subframe with an odd count of ones sets `err_out` for that subframe only.
- R4: A strobed subframe with `sf_bpv` high sets `err_out`. A later clean subframe clears it.
- R5: While `rx_lock` is low, `err_out` and `verr_out` are 1 from the next cycle on, with or without strobes, and `blk_out` is 0.
- R6: After each strobe with lock present, `verr_out` equals the subframe's V bit ORed with its error condition.
- R7: A strobed subframe with preamble code 2'b00 (block start) sets the frame position to 0 and drives `blk_out` to 1.
- R8: A subframe with code 2'b01 (first channel) advances the frame position by one. Codes 2'b10 (second channel) and 2'b11 leave it unchanged. `blk_out` is 1 at positions 0 to 31 and 0 at positions 32 to 191.
- R9: A first-channel subframe at position 191 wraps the position to 0 and drives `blk_out` to 1, with no block-start preamble needed.
- R10: A block-start preamble at any position other than 191 restarts the count at 0.
- R11: After reset, and after any loss of lock, `blk_out` stays 0 until a block-start preamble is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_valid | input | 1 | Subframe strobe, one cycle per decoded subframe |
| sf_data | input | DATA_W | Audio payload bits of the subframe |
| sf_pre | input | 2 | Preamble code: 00 block start, 01 first channel, 10 second channel |
| sf_v | input | 1 | Validity bit |
| sf_u | input | 1 | User-data bit |
| sf_c | input | 1 | Channel-status bit |
| sf_p | input | 1 | Parity bit |
| sf_bpv | input | 1 | Biphase coding violation seen in this subframe |
| rx_lock | input | 1 | Receiver clock recovery is locked |
| cs_out | output | 1 | Channel-status bit of the last subframe |
| usr_out | output | 1 | User bit of the last subframe |
| err_out | output | 1 | Error flag for the last sample |
| verr_out | output | 1 | Validity ORed with the error flag |
| blk_out | output | 1 | High during the first 32 frames of a channel-status block |

## Verification
The bench walks one full block and checks the edges at frames 31 and 32. A counter that is off by one would move the window edge, and one that counted second-channel subframes would close the window after 16 frames. It then runs past frame 191 with no block-start preamble to confirm the wrap. It also sends a block-start preamble at frame 50, which a design that only resynchronised at the wrap would ignore. It drops lock with no strobes to catch error logic that is only evaluated on strobes. After lock returns it checks that the window stays shut, which a design keeping a stale frame position would get wrong. Finally it checks that a parity or violation error clears on the next clean subframe rather than sticking.

// File: rtl/aud_rx_side_pkg.sv
package aud_rx_side_pkg;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'b00,
    PRE_CH_A  = 2'b01,
    PRE_CH_B  = 2'b10,
    PRE_RSVD  = 2'b11
  } pre_e;

  // Even parity: an odd number of ones over payload, V, U, C and P is a fault.
  function automatic logic parity_fault(input logic payload_xor, input logic v,
                                        input logic u, input logic c, input logic p);
    return payload_xor ^ v ^ u ^ c ^ p;
  endfunction

  // Next frame position given the current one and the preamble seen.
  function automatic int unsigned frame_step(input int unsigned pos, input pre_e pre,
                                             input int unsigned frames);
    int unsigned r;
    case (pre)
      PRE_BLOCK: r = 0;
      PRE_CH_A:  r = (pos == frames - 1) ? 0 : pos + 1;
      default:   r = pos;
    endcase
    return r;
  endfunction

  // Block-window rule: high for positions below the head length.
  function automatic logic in_head(input int unsigned pos, input int unsigned head);
    return pos < head;
  endfunction

endpackage

// File: rtl/aud_rx_parity.sv
module aud_rx_parity
  import aud_rx_side_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] data,
  input  logic              v,
  input  logic              u,
  input  logic              c,
  input  logic              p,
  output logic              fault
);
  logic payload_xor;

  assign payload_xor = ^data;
  assign fault       = parity_fault(payload_xor, v, u, c, p);
endmodule

// File: rtl/aud_rx_frame_ctr.sv
module aud_rx_frame_ctr
  import aud_rx_side_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int HEAD   = 32,
  localparam int CW    = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          lock,
  input  logic [1:0]    pre,
  output logic [CW-1:0] pos,
  output logic          synced,
  output logic          window
);
  logic [CW-1:0] pos_nxt;

  assign pos_nxt = CW'(frame_step(int'(pos), pre_e'(pre), FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      synced <= 1'b0;
    end else if (!lock) begin
      pos    <= '0;
      synced <= 1'b0;
    end else if (strobe) begin
      pos <= pos_nxt;
      if (pre_e'(pre) == PRE_BLOCK) synced <= 1'b1;
    end
  end

  assign window = synced && in_head(int'(pos), HEAD);
endmodule

// File: rtl/aud_rx_side_regs.sv
module aud_rx_side_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic lock,
  input  logic c,
  input  logic u,
  input  logic v,
  input  logic par_fault,
  input  logic bpv,
  output logic cs_q,
  output logic usr_q,
  output logic err_q,
  output logic verr_q
);
  logic sample_err;

  assign sample_err = par_fault | bpv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b0;
      usr_q <= 1'b0;
    end else if (strobe) begin
      cs_q  <= c;
      usr_q <= u;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      verr_q <= 1'b0;
    end else if (!lock) begin
      err_q  <= 1'b1;
      verr_q <= 1'b1;
    end else if (strobe) begin
      err_q  <= sample_err;
      verr_q <= v | sample_err;
    end
  end
endmodule

// File: rtl/aud_rx_side_info.sv
module aud_rx_side_info #(
  parameter int DATA_W = 24,
  parameter int FRAMES = 192,
  parameter int HEAD   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_valid,
  input  logic [DATA_W-1:0] sf_data,
  input  logic [1:0]        sf_pre,
  input  logic              sf_v,
  input  logic              sf_u,
  input  logic              sf_c,
  input  logic              sf_p,
  input  logic              sf_bpv,
  input  logic              rx_lock,
  output logic              cs_out,
  output logic              usr_out,
  output logic              err_out,
  output logic              verr_out,
  output logic              blk_out
);
  localparam int CW = $clog2(FRAMES);

  logic          par_fault;
  logic [CW-1:0] frame_idx;
  logic          frame_synced;

  aud_rx_parity #(.DATA_W(DATA_W)) u_par (
    .data (sf_data),
    .v    (sf_v),
    .u    (sf_u),
    .c    (sf_c),
    .p    (sf_p),
    .fault(par_fault)
  );

  aud_rx_frame_ctr #(.FRAMES(FRAMES), .HEAD(HEAD)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(sf_valid),
    .lock  (rx_lock),
    .pre   (sf_pre),
    .pos   (frame_idx),
    .synced(frame_synced),
    .window(blk_out)
  );

  aud_rx_side_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (sf_valid),
    .lock     (rx_lock),
    .c        (sf_c),
    .u        (sf_u),
    .v        (sf_v),
    .par_fault(par_fault),
    .bpv      (sf_bpv),
    .cs_q     (cs_out),
    .usr_q    (usr_out),
    .err_q    (err_out),
    .verr_q   (verr_out)
  );
endmodule

// File: rtl/aud_rx_side_chk.sv
module aud_rx_side_chk #(
  parameter int FRAMES = 192,
  parameter int HEAD   = 32,
  localparam int CW    = $clog2(FRAMES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sf_valid,
  input logic [1:0]    sf_pre,
  input logic          sf_bpv,
  input logic          rx_lock,
  input logic          par_fault,
  input logic [CW-1:0] frame_idx,
  input logic          frame_synced,
  input logic          cs_out,
  input logic          usr_out,
  input logic          err_out,
  input logic          verr_out,
  input logic          blk_out
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_valid |=> $stable(cs_out) && $stable(usr_out));

  assert_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid && par_fault |=> err_out);

  assert_bpv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid && sf_bpv |=> err_out);

  assert_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_lock |=> err_out && verr_out && !blk_out && !frame_synced);

  assert_verr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_out |-> verr_out);

  assert_bstart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid && rx_lock && sf_pre == 2'b00 |=> blk_out && frame_idx == '0);

  assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_out |-> frame_idx < CW'(HEAD));

  assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx < CW'(FRAMES));

  assert_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_out) |-> $past(sf_valid) && $past(rx_lock));
endmodule

bind aud_rx_side_info aud_rx_side_chk #(.FRAMES(FRAMES), .HEAD(HEAD)) u_side_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sf_valid    (sf_valid),
  .sf_pre      (sf_pre),
  .sf_bpv      (sf_bpv),
  .rx_lock     (rx_lock),
  .par_fault   (par_fault),
  .frame_idx   (frame_idx),
  .frame_synced(frame_synced),
  .cs_out      (cs_out),
  .usr_out     (usr_out),
  .err_out     (err_out),
  .verr_out    (verr_out),
  .blk_out     (blk_out)
);

// File: tb/test_aud_rx_side_info.sv
`timescale 1ns/1ps
module test_aud_rx_side_info;
  localparam int DATA_W = 24;
  localparam int FRAMES = 192;
  localparam int HEAD   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sf_valid = 1'b0;
  logic [DATA_W-1:0] sf_data = '0;
  logic [1:0] sf_pre = 2'b10;
  logic sf_v = 0, sf_u = 0, sf_c = 0, sf_p = 0, sf_bpv = 0, rx_lock = 1;
  logic cs_out, usr_out, err_out, verr_out, blk_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aud_rx_side_info #(.DATA_W(DATA_W), .FRAMES(FRAMES), .HEAD(HEAD)) i_aud_rx_side_info (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_data(sf_data), .sf_pre(sf_pre),
    .sf_v(sf_v), .sf_u(sf_u), .sf_c(sf_c), .sf_p(sf_p), .sf_bpv(sf_bpv), .rx_lock(rx_lock),
    .cs_out(cs_out), .usr_out(usr_out), .err_out(err_out), .verr_out(verr_out),
    .blk_out(blk_out)
  );

  // Vector fields: [12:11] pre, 10 v, 9 u, 8 c, 7 bpv, 6 force bad parity,
  // 5 exp cs, 4 exp usr, 3 exp err, 2 exp verr, 1 exp blk, 0 spare
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    13'b00_0_1_0_0_0_0_1_0_0_1_0,
    13'b10_0_0_1_0_0_1_0_0_0_1_0,
    13'b01_1_0_0_0_0_0_0_0_1_1_0,
    13'b10_0_1_1_0_1_1_1_1_1_1_0,
    13'b01_0_0_0_1_0_0_0_1_1_1_0,
    13'b10_1_1_0_0_1_0_1_1_1_1_0,
    13'b01_0_1_1_0_0_1_1_0_0_1_0,
    13'b10_0_0_0_0_0_0_0_0_0_1_0
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive one subframe for one cycle; return at the following negedge,
  // after the capturing edge, with the strobe low again.
  task automatic send(input logic [1:0] pre, input logic v, input logic u, input logic c,
                      input logic bpv, input logic bad, input logic [DATA_W-1:0] d);
    @(negedge clk);
    sf_pre = pre; sf_v = v; sf_u = u; sf_c = c; sf_bpv = bpv; sf_data = d;
    sf_p = (^d) ^ v ^ u ^ c ^ bad;
    sf_valid = 1'b1;
    @(negedge clk);
    sf_valid = 1'b0; sf_bpv = 1'b0;
  endtask

  task automatic clean(input logic [1:0] pre);
    send(pre, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h3C5A96);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "cs", cs_out, 0);   check("R1", "usr", usr_out, 0);
    check("R1", "err", err_out, 0); check("R1", "verr", verr_out, 0);
    check("R1", "blk", blk_out, 0);
    rst_n = 1'b1;

    // R11: no window before the first block start
    clean(2'b01); clean(2'b10);
    check("R11", "blk before sync", blk_out, 0);

    // Table walk: R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [12:0] e;
      e = VEC[i];
      send(e[12:11], e[10], e[9], e[8], e[7], e[6], 24'hA5A5A5 ^ DATA_W'(i * 32'h13579));
      check("R2", $sformatf("vec%0d cs", i), cs_out, e[5]);
      check("R2", $sformatf("vec%0d usr", i), usr_out, e[4]);
      check("R3_R4", $sformatf("vec%0d err", i), err_out, e[3]);
      check("R6", $sformatf("vec%0d verr", i), verr_out, e[2]);
      check("R7", $sformatf("vec%0d blk", i), blk_out, e[1]);
    end

    // R2: outputs hold between strobes
    send(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h000001);
    repeat (4) @(negedge clk);
    check("R2", "cs hold", cs_out, 1);
    check("R2", "usr hold", usr_out, 1);

    // R7/R8/R9: full block walk
    clean(2'b00);
    check("R7", "blk at frame 0", blk_out, 1);
    clean(2'b10);
    for (int f = 1; f < FRAMES; f++) begin
      clean(2'b01);
      if (f == 1 || f == HEAD - 1 || f == HEAD || f == FRAMES - 1)
        check("R8", $sformatf("blk frame %0d", f), blk_out, logic'(f < HEAD));
      clean(2'b10);
      if (f == HEAD - 1) check("R8", "second channel holds", blk_out, 1);
      if (f == HEAD) check("R8", "second channel holds low", blk_out, 0);
    end
    clean(2'b01);
    check("R9", "wrap to frame 0", blk_out, 1);

    // R10: restart mid-block
    for (int f = 1; f <= 50; f++) begin clean(2'b01); clean(2'b10); end
    check("R10", "blk at frame 50", blk_out, 0);
    clean(2'b00);
    check("R10", "blk after restart", blk_out, 1);
    for (int f = 1; f < HEAD; f++) begin clean(2'b01); clean(2'b10); end
    check("R10", "frame 31 after restart", blk_out, 1);
    clean(2'b01);
    check("R10", "frame 32 after restart", blk_out, 0);

    // R5: loss of lock, no strobes
    clean(2'b00);
    @(negedge clk); rx_lock = 1'b0;
    repeat (3) @(negedge clk);
    check("R5", "err unlocked", err_out, 1);
    check("R5", "verr unlocked", verr_out, 1);
    check("R5", "blk unlocked", blk_out, 0);
    rx_lock = 1'b1;
    clean(2'b01);
    check("R5", "err after relock", err_out, 0);
    check("R11", "blk after relock", blk_out, 0);
    clean(2'b00);
    check("R11", "blk after block start", blk_out, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule